// File: doc/BRIEF.md
# Pad pull sequencer

This block holds the pull-resistor setting (none, pull-down, pull-up) of every pad in a pin bank and changes it only through a two-step handshake. Software first writes a 2-bit pull code into one shared control register. It then raises the clock bit of each pad to be changed in a bank clock register, keeps it raised for a minimum time, and writes the clock register back to zero. A pad takes the shared code once its clock bit has been high for a parameterised number of consecutive cycles. Every other pad keeps the setting it already had.

Each pad's setting drives two outputs toward the pad ring: a pull enable, and a pull direction select. The block sits on a plain 32-bit register bus with a select, a write flag, a byte address and registered read data. The pull resistors themselves are outside the block. So is the software that times the handshake.

Top module: `pad_pull_sequencer`

## Requirements
- R1: After reset, the control register reads 0 and every pad holds the setting given by the RESET_MODE parameter.
- R2: The control register sits at byte address 0x94. Only written bits [1:0] are kept, and a read returns them with bits [31:2] at 0.
- R3: Clock bank b sits at byte address 0x98 + 4*b, where bit i of bank b belongs to pad 32*b + i. A read returns the last written value, and bits with no pad behind them read 0.
- R4: Read data is registered. It appears on the cycle after the read request and holds until the next read. A read of any other address returns 0.
- R5: When a pad's clock bit has been high for HOLD_CYCLES consecutive cycles, the pad takes the control value present in that last cycle. Its outputs change on that clock edge.
- R6: A clock pulse shorter than HOLD_CYCLES cycles leaves the pad unchanged. The next pulse counts from zero.
- R7: A pad whose clock bit stays 0 keeps its setting, whatever the control register holds.
- R8: Code 3 is reserved. If it is present when a pad's hold time completes, the pad keeps its previous setting.
- R9: Code 0 gives pull_en=0 and pull_up=0. Code 1 gives pull_en=1 and pull_up=0. Code 2 gives pull_en=1 and pull_up=1.
- R10: A single continuous high pulse updates a pad at most once. Changing the control value while the bit stays high has no further effect.
- R11: Pads in the same bank and pads in different banks can be updated by overlapping pulses, and each one latches independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pull_en | output | NUM_PINS | Per-pad pull enable |
| pull_up | output | NUM_PINS | Per-pad pull direction, 1 = up |

## Verification
The bench builds the block with 40 pads, so the second clock bank has only eight live bits. This exposes the masking of unpopulated bits on both write and read. HOLD_CYCLES is set to 5, which puts pulses one cycle short of the threshold and exactly at it within a few bus writes. RESET_MODE is set to pull-down, so the reset setting differs from both the cleared control register and the no-pull code.

// File: rtl/pad_pull_pkg.sv
package pad_pull_pkg;

   localparam int BUS_W  = 32;
   localparam int BANK_W = 32;

   typedef enum logic [1:0] {
      PULL_NONE = 2'd0,
      PULL_DOWN = 2'd1,
      PULL_UP   = 2'd2,
      PULL_RSVD = 2'd3
   } pull_mode_e;

   function automatic logic pull_enabled(pull_mode_e m);
      return (m == PULL_DOWN) || (m == PULL_UP);
   endfunction

   function automatic logic pull_is_up(pull_mode_e m);
      return (m == PULL_UP);
   endfunction

endpackage

// File: rtl/pad_pull_regs.sv
module pad_pull_regs
   import pad_pull_pkg::*;
#(
   parameter int          NUM_PINS  = 54,
   parameter int          ADDR_W    = 8,
   parameter logic [31:0] CTRL_ADDR = 32'h94,
   parameter logic [31:0] CLK_BASE  = 32'h98
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [BUS_W-1:0]      bus_wdata,
   output logic [BUS_W-1:0]      bus_rdata,
   output pull_mode_e            ctrl_mode,
   output logic [NUM_PINS-1:0]   clk_bits
);

   localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

   logic              wr_en;
   logic              rd_en;
   logic              ctrl_hit;
   logic [1:0]        ctrl_q;
   logic [BUS_W-1:0]  rd_mux;
   logic [BUS_W-1:0]  rdata_q;
   logic [NUM_BANKS-1:0] bank_hit;
   logic [BUS_W-1:0]  bank_rd [NUM_BANKS];

   assign wr_en    = bus_sel & bus_we;
   assign rd_en    = bus_sel & ~bus_we;
   assign ctrl_hit = (bus_addr == ADDR_W'(CTRL_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= 2'd0;
      else if (wr_en && ctrl_hit)
         ctrl_q <= bus_wdata[1:0];
   end

   assign ctrl_mode = pull_mode_e'(ctrl_q);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int LO  = b * BANK_W;
      localparam int CNT = (NUM_PINS - LO > BANK_W) ? BANK_W : (NUM_PINS - LO);

      logic [CNT-1:0] bits_q;

      assign bank_hit[b] = (bus_addr == ADDR_W'(CLK_BASE + 32'(4 * b)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bits_q <= '0;
         else if (wr_en && bank_hit[b])
            bits_q <= bus_wdata[CNT-1:0];
      end

      assign clk_bits[LO +: CNT] = bits_q;
      assign bank_rd[b]          = BUS_W'(bits_q);
   end

   always_comb begin
      rd_mux = '0;
      if (ctrl_hit)
         rd_mux = {30'd0, ctrl_q};
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_hit[b])
            rd_mux = bank_rd[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_en)
         rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;

   // R4: a read request is answered on the following cycle.
   a_r4_read_registered: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en) |-> $stable(bus_rdata));

   // R2: the control readback never shows bits above [1:0].
   a_r2_ctrl_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_en) && $past(ctrl_hit)) |-> (bus_rdata[31:2] == 30'd0));

endmodule

// File: rtl/pad_pull_cell.sv
module pad_pull_cell
   import pad_pull_pkg::*;
#(
   parameter int         HOLD_CYCLES = 150,
   parameter logic [1:0] RESET_MODE  = 2'd0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clk_bit,
   input  pull_mode_e ctrl_mode,
   output pull_mode_e mode_q
);

   localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(HOLD_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic             latch_hit;

   assign latch_hit = clk_bit && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!clk_bit)
         cnt_q <= '0;
      else if (cnt_q != FULL)
         cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= pull_mode_e'(RESET_MODE);
      else if (latch_hit && (ctrl_mode != PULL_RSVD))
         mode_q <= ctrl_mode;
   end

   // R7: a pad whose clock bit was low keeps its setting.
   a_r7_idle_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clk_bit) |-> $stable(mode_q));

   // R8: the reserved code never reaches the pad state.
   a_r8_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      $past(latch_hit && (ctrl_mode == PULL_RSVD)) |-> $stable(mode_q));

   // R5: a completed hold time loads the control value of that cycle.
   a_r5_latch_takes_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      $past(latch_hit && (ctrl_mode != PULL_RSVD)) |-> (mode_q == $past(ctrl_mode)));

   // R6: every new pulse starts counting from zero.
   a_r6_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_bit) |-> (cnt_q == '0));

endmodule

// File: rtl/pad_pull_drive.sv
module pad_pull_drive
   import pad_pull_pkg::*;
#(
   parameter int NUM_PINS = 54
) (
   input  pull_mode_e          mode [NUM_PINS],
   output logic [NUM_PINS-1:0] pull_en,
   output logic [NUM_PINS-1:0] pull_up
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
      assign pull_en[p] = pull_enabled(mode[p]);
      assign pull_up[p] = pull_is_up(mode[p]);
   end

endmodule

// File: rtl/pad_pull_sequencer.sv
module pad_pull_sequencer
   import pad_pull_pkg::*;
#(
   parameter int          NUM_PINS    = 54,
   parameter int          HOLD_CYCLES = 150,
   parameter int          ADDR_W      = 8,
   parameter logic [31:0] CTRL_ADDR   = 32'h94,
   parameter logic [31:0] CLK_BASE    = 32'h98,
   parameter logic [1:0]  RESET_MODE  = 2'd0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic [NUM_PINS-1:0] pull_en,
   output logic [NUM_PINS-1:0] pull_up
);

   localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
   localparam longint MAP_END = longint'(CLK_BASE) + 4 * NUM_BANKS;

   if (NUM_PINS < 1 || NUM_PINS > 1024) begin : g_bad_pins
      $error("NUM_PINS out of range");
   end
   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("HOLD_CYCLES must be at least 1");
   end
   if (MAP_END > (longint'(1) << ADDR_W)) begin : g_bad_map
      $error("clock banks do not fit in the address space");
   end
   if (CTRL_ADDR >= CLK_BASE && longint'(CTRL_ADDR) < MAP_END) begin : g_bad_overlap
      $error("control register overlaps a clock bank");
   end
   if (RESET_MODE == 2'd3) begin : g_bad_reset
      $error("RESET_MODE may not be the reserved code");
   end

   pull_mode_e          ctrl_mode;
   logic [NUM_PINS-1:0] clk_bits;
   pull_mode_e          pad_mode [NUM_PINS];

   pad_pull_regs #(
      .NUM_PINS  (NUM_PINS),
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR),
      .CLK_BASE  (CLK_BASE)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ctrl_mode (ctrl_mode),
      .clk_bits  (clk_bits)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_cell
      pad_pull_cell #(
         .HOLD_CYCLES (HOLD_CYCLES),
         .RESET_MODE  (RESET_MODE)
      ) cell_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .clk_bit   (clk_bits[p]),
         .ctrl_mode (ctrl_mode),
         .mode_q    (pad_mode[p])
      );
   end

   pad_pull_drive #(
      .NUM_PINS (NUM_PINS)
   ) drive_i (
      .mode    (pad_mode),
      .pull_en (pull_en),
      .pull_up (pull_up)
   );

   // R9: a pull-up select is never driven without its enable.
   a_r9_up_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_up & ~pull_en) == '0);

endmodule

// File: tb/pad_pull_sequencer_tb.sv
module pad_pull_sequencer_tb_top;

   localparam int         NP   = 40;
   localparam int         HOLD = 5;
   localparam int         AW   = 8;
   localparam logic [1:0] RSTM = 2'd1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pull_en;
   logic [NP-1:0] pull_up;

   always #10 clk = ~clk;

   pad_pull_sequencer #(
      .NUM_PINS    (NP),
      .HOLD_CYCLES (HOLD),
      .ADDR_W      (AW),
      .RESET_MODE  (RSTM)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pull_en   (pull_en),
      .pull_up   (pull_up)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // behavioural reference model
   logic [1:0]    m_ctrl;
   logic [NP-1:0] m_bits;
   int            m_cnt [NP];
   logic [1:0]    m_st [NP];
   logic [31:0]   m_rdata;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl  = 2'd0;
         m_bits  = '0;
         m_rdata = '0;
         for (int p = 0; p < NP; p++) begin
            m_cnt[p] = 0;
            m_st[p]  = RSTM;
         end
      end else begin
         if (bus_sel && !bus_we) begin
            case (bus_addr)
               8'h94:   m_rdata = {30'd0, m_ctrl};
               8'h98:   m_rdata = m_bits[31:0];
               8'h9C:   m_rdata = {24'd0, m_bits[NP-1:32]};
               default: m_rdata = 32'd0;
            endcase
         end
         for (int p = 0; p < NP; p++) begin
            if (m_bits[p]) begin
               if (m_cnt[p] < HOLD) begin
                  if (m_cnt[p] == HOLD - 1 && m_ctrl != 2'd3)
                     m_st[p] = m_ctrl;
                  m_cnt[p]++;
               end
            end else begin
               m_cnt[p] = 0;
            end
         end
         if (bus_sel && bus_we) begin
            if (bus_addr == 8'h94) m_ctrl = bus_wdata[1:0];
            if (bus_addr == 8'h98) m_bits[31:0] = bus_wdata;
            if (bus_addr == 8'h9C) m_bits[NP-1:32] = bus_wdata[NP-33:0];
         end
      end
   end

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // compare against the model on every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NP-1:0] e_en, e_up;
         for (int p = 0; p < NP; p++) begin
            e_en[p] = (m_st[p] == 2'd1) || (m_st[p] == 2'd2);
            e_up[p] = (m_st[p] == 2'd2);
         end
         chk("R5 R9 model pull_en", 64'(pull_en), 64'(e_en));
         chk("R5 R9 model pull_up", 64'(pull_up), 64'(e_up));
         chk("R4 model rdata", 64'(bus_rdata), 64'(m_rdata));
      end
   end

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      chk(req, 64'(bus_rdata), 64'(exp));
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] lf;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      chk("R1 reset pull_en", 64'(pull_en), 64'({NP{1'b1}}));
      chk("R1 reset pull_up", 64'(pull_up), 64'(0));
      rd(8'h94, 32'd0, "R1 reset ctrl");

      // R2, R3, R4 register map, with code 3 so holds latch nothing (R8)
      wr(8'h94, 32'hFFFF_FFFF);
      rd(8'h94, 32'd3, "R2 ctrl keeps bits 1:0");
      wr(8'h98, 32'hA5A5_0001);
      rd(8'h98, 32'hA5A5_0001, "R3 bank0 readback");
      wr(8'h9C, 32'hFFFF_FFFF);
      rd(8'h9C, 32'h0000_00FF, "R3 bank1 unpopulated bits read 0");
      rd(8'h40, 32'd0, "R4 unmapped read");
      idle(10);
      chk("R8 reserved code keeps pull_en", 64'(pull_en), 64'({NP{1'b1}}));
      chk("R8 reserved code keeps pull_up", 64'(pull_up), 64'(0));
      wr(8'h98, 32'd0);
      wr(8'h9C, 32'd0);

      wr(8'h94, 32'hFFFF_FFFE);
      rd(8'h94, 32'd2, "R2 ctrl readback pull-up");

      // R6: pulse one cycle short of HOLD
      wr(8'h98, 32'h8);
      idle(2);
      wr(8'h98, 32'h0);
      idle(2);
      chk("R6 short pulse pull_up[3]", 64'(pull_up[3]), 64'(0));
      chk("R6 short pulse pull_en[3]", 64'(pull_en[3]), 64'(1));

      // R5: pulse of exactly HOLD cycles
      wr(8'h98, 32'h8);
      idle(3);
      wr(8'h98, 32'h0);
      chk("R5 exact pulse pull_up[3]", 64'(pull_up[3]), 64'(1));

      // R7: control change without clock bits
      wr(8'h94, 32'd0);
      idle(10);
      chk("R7 idle pad keeps pull_up[3]", 64'(pull_up[3]), 64'(1));
      chk("R7 idle pads keep pull_en", 64'(pull_en), 64'({NP{1'b1}}));

      // R10: one latch per continuous pulse
      wr(8'h98, 32'h20);
      idle(8);
      chk("R10 first latch pull_en[5]", 64'(pull_en[5]), 64'(0));
      wr(8'h94, 32'd2);
      idle(8);
      chk("R10 no relatch pull_en[5]", 64'(pull_en[5]), 64'(0));
      wr(8'h98, 32'h0);

      // R11: overlapping pulses in two banks
      wr(8'h98, 32'h1);
      wr(8'h9C, 32'h8);
      idle(8);
      wr(8'h98, 32'h0);
      wr(8'h9C, 32'h0);
      chk("R11 bank0 pad0 up", 64'(pull_up[0]), 64'(1));
      chk("R11 bank1 pad35 up", 64'(pull_up[35]), 64'(1));

      // R9: encoding of each code on the pads
      chk("R9 code2 pad0", 64'({pull_en[0], pull_up[0]}), 64'(2'b11));
      chk("R9 code0 pad5", 64'({pull_en[5], pull_up[5]}), 64'(2'b00));
      chk("R9 code1 pad1", 64'({pull_en[1], pull_up[1]}), 64'(2'b10));

      // mixed traffic, checked against the model every cycle
      lf = 16'hACE1;
      for (int k = 0; k < 60; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         case (lf[1:0])
            2'd0: wr(8'h94, {16'd0, lf});
            2'd1: wr(8'h98, {lf, lf[7:0], lf[15:8]});
            2'd2: wr(8'h9C, {16'd0, lf});
            default: rd(lf[2] ? 8'h98 : 8'h9C,
                        lf[2] ? m_bits[31:0] : {24'd0, m_bits[NP-1:32]},
                        "R3 random readback");
         endcase
         idle(int'(lf[5:3]));
      end

      // R1: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk("R1 re-reset pull_en", 64'(pull_en), 64'({NP{1'b1}}));
      chk("R1 re-reset pull_up", 64'(pull_up), 64'(0));
      rd(8'h98, 32'd0, "R1 re-reset bank0");
      idle(2);
      finish_run();
   end

endmodule